// File: doc/BRIEF.md
# Dual-Pattern Serial Sequence Detector

This block watches a serial bit stream, one bit per clock cycle, and raises a single output bit in the same cycle as any bit that completes either of two patterns. The patterns are 0,1,0 and 1,0,0,1, where the oldest bit comes first. Matches may overlap, both within one pattern and across the two, so the tail of one match can begin the next. An input-valid qualifier marks the cycles that carry a bit. In a cycle where the qualifier is low, the machine keeps its state and the output stays low. A synchronous active-high reset returns the machine to the empty-history state.

The block is a Mealy machine with six states held in a three-bit register of D flip-flops. No two of the six states are equivalent. Each state names the longest tail of the stream that is still the start of a pattern:

- `ST_EMPTY`: no useful history.
- `ST_SAW0`: the stream ends in 0, and no pattern is partly matched beyond that 0.
- `ST_SAW01`: the stream ends in 0,1.
- `ST_SAW1`: the stream ends in 1, and no longer pattern start is pending.
- `ST_SAW10`: the stream ends in 1,0.
- `ST_SAW100`: the stream ends in 1,0,0.

The transitions on a valid bit are given below as state, then next state on 0 and next state on 1, with the output in brackets:

| State | Next state on 0 | Next state on 1 |
|---|---|---|
| `ST_EMPTY` | `ST_SAW0` [0] | `ST_SAW1` [0] |
| `ST_SAW0` | `ST_SAW0` [0] | `ST_SAW01` [0] |
| `ST_SAW01` | `ST_SAW10` [1] | `ST_SAW1` [0] |
| `ST_SAW1` | `ST_SAW10` [0] | `ST_SAW1` [0] |
| `ST_SAW10` | `ST_SAW100` [0] | `ST_SAW01` [0] |
| `ST_SAW100` | `ST_SAW0` [0] | `ST_SAW01` [1] |

Top module: `dual_pattern_detector`

## Requirements
- R1: After a cycle with `rst` high, the machine holds no history. With `in_valid` low the output is 0. A first valid bit of 0 or 1 gives output 0.
- R2: The output `det_out` is 1 in a valid cycle whose bit completes 0,1,0, with the oldest bit first, across the valid bits received since reset.
- R3: The output `det_out` is 1 in a valid cycle whose bit completes 1,0,0,1, with the oldest bit first, across the valid bits received since reset.
- R4: The output is 0 for every other valid history. Sequences such as 0,0,0,1 or 1,1,0 do not assert it.
- R5: Matches overlap. The stream 1,0,0,1,0 asserts the output on its fourth and fifth bits. The stream 0,1,0,0,1 asserts it on its third and fifth bits.
- R6: A cycle with `in_valid` low forces `det_out` to 0 and leaves the state unchanged. Bits on either side of such a gap still combine into a match.
- R7: The output is a Mealy output. It changes in the same cycle as the bit that completes a match, with no added register delay.
- R8: Reset discards any partial match. After 1,0,0 then a reset, a valid 1 gives output 0. After 0,1 then a reset, a valid 0 gives output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to `ST_EMPTY` |
| in_valid | input | 1 | High in cycles that carry a serial bit |
| in_bit | input | 1 | Serial data bit |
| det_out | output | 1 | Mealy match flag, high when the current bit completes a pattern |

## Verification
On every cycle, the assertions check four things. Reset leads to the empty state. A gap in `in_valid` keeps the state unchanged and the output low. A match can only come from `ST_SAW01` on a 0 or from `ST_SAW100` on a 1. A match always leaves the machine in `ST_SAW10` or `ST_SAW01`, which keeps the overlapping tail. Only the bench's streams can show that the output agrees with the full pattern definition, which is a shift register of the last four valid bits. Those streams also show overlapping matches, matches across gaps in `in_valid`, and the loss of partial history after a reset in mid-stream.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
    localparam int unsigned STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_EMPTY  = 3'd0,
        ST_SAW0   = 3'd1,
        ST_SAW01  = 3'd2,
        ST_SAW1   = 3'd3,
        ST_SAW10  = 3'd4,
        ST_SAW100 = 3'd5
    } seq_state_t;
endpackage

// File: rtl/seqdet_next_state.sv
module seqdet_next_state
    import seqdet_pkg::*;
(
    input  seq_state_t cur_state,
    input  logic       bit_in,
    input  logic       bit_valid,
    output seq_state_t nxt_state
);
    always_comb begin
        nxt_state = cur_state;
        if (bit_valid) begin
            unique case (cur_state)
                ST_EMPTY:  nxt_state = bit_in ? ST_SAW1  : ST_SAW0;
                ST_SAW0:   nxt_state = bit_in ? ST_SAW01 : ST_SAW0;
                ST_SAW01:  nxt_state = bit_in ? ST_SAW1  : ST_SAW10;
                ST_SAW1:   nxt_state = bit_in ? ST_SAW1  : ST_SAW10;
                ST_SAW10:  nxt_state = bit_in ? ST_SAW01 : ST_SAW100;
                ST_SAW100: nxt_state = bit_in ? ST_SAW01 : ST_SAW0;
                default:   nxt_state = ST_EMPTY;
            endcase
        end
    end
endmodule

// File: rtl/seqdet_match_out.sv
module seqdet_match_out
    import seqdet_pkg::*;
(
    input  seq_state_t cur_state,
    input  logic       bit_in,
    input  logic       bit_valid,
    output logic       hit
);
    always_comb begin
        hit = 1'b0;
        if (bit_valid) begin
            unique case (cur_state)
                ST_SAW01:  hit = ~bit_in;
                ST_SAW100: hit = bit_in;
                default:   hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dual_pattern_detector.sv
module dual_pattern_detector
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic det_out
);
    seq_state_t state_q;
    seq_state_t state_d;

    seqdet_next_state u_next (
        .cur_state (state_q),
        .bit_in    (in_bit),
        .bit_valid (in_valid),
        .nxt_state (state_d)
    );

    seqdet_match_out u_match (
        .cur_state (state_q),
        .bit_in    (in_bit),
        .bit_valid (in_valid),
        .hit       (det_out)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (state_q == ST_EMPTY));

    // R6
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (state_q == $past(state_q)));

    // R6
    gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !det_out);

    // R2
    // R3
    hit_source_chk: assert property (@(posedge clk) disable iff (rst)
        det_out |-> ((state_q == ST_SAW01 && !in_bit) ||
                     (state_q == ST_SAW100 && in_bit)));

    // R5
    hit_tail_chk: assert property (@(posedge clk) disable iff (rst)
        det_out |=> (state_q == ST_SAW10 || state_q == ST_SAW01));
endmodule

// File: tb/test_dual_pattern_detector.sv
module test_dual_pattern_detector;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic det_out;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit finished = 1'b0;

    logic [3:0] hist = 4'b0;
    int unsigned depth = 0;

    always #5 clk = ~clk;

    dual_pattern_detector i_dual_pattern_detector (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .det_out(det_out)
    );

    // {valid, bit, expected}
    localparam int NV = 21;
    localparam logic [2:0] VEC [NV] = '{
        3'b110, 3'b100, 3'b100, 3'b111, 3'b101, 3'b110, 3'b101,
        3'b010, 3'b100, 3'b010, 3'b111, 3'b110, 3'b110, 3'b100,
        3'b100, 3'b100, 3'b110, 3'b101, 3'b100, 3'b111, 3'b110
    };

    function automatic logic model_hit(input logic v, input logic b);
        logic p3;
        logic p4;
        p3 = (depth >= 2) && ({hist[1:0], b} == 3'b010);
        p4 = (depth >= 3) && ({hist[2:0], b} == 4'b1001);
        return v && (p3 || p4);
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: det_out=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic b,
                        output logic got, output logic exp);
        @(negedge clk);
        rst = r; in_valid = v; in_bit = b;
        #2;
        got = det_out;
        exp = model_hit(v, b);
        @(posedge clk);
        if (r) begin
            depth = 0; hist = 4'b0;
        end else if (v) begin
            hist = {hist[2:0], b};
            if (depth < 4) depth++;
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: det_out=%b expected=end of run", det_out);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic g;
        logic e;
        step(1'b1, 1'b0, 1'b0, g, e);
        // R1: idle output after reset
        step(1'b0, 1'b0, 1'b1, g, e); check("R1 idle", g, 1'b0);
        step(1'b0, 1'b1, 1'b0, g, e); check("R1 first bit", g, 1'b0);
        step(1'b1, 1'b0, 1'b0, g, e);
        step(1'b0, 1'b1, 1'b1, g, e); check("R1 first bit one", g, 1'b0);
        step(1'b1, 1'b0, 1'b0, g, e);

        // R2 R3 R4 R5 R6 R7: directed table, one bit per cycle, checked in the same cycle
        for (int i = 0; i < NV; i++) begin
            step(1'b0, VEC[i][2], VEC[i][1], g, e);
            check("R2/R3/R4/R5/R6/R7 table", g, VEC[i][0]);
        end

        // R8: reset discards partial 1001
        step(1'b1, 1'b0, 1'b0, g, e);
        step(1'b0, 1'b1, 1'b1, g, e);
        step(1'b0, 1'b1, 1'b0, g, e);
        step(1'b0, 1'b1, 1'b0, g, e);
        step(1'b1, 1'b0, 1'b0, g, e);
        step(1'b0, 1'b1, 1'b1, g, e); check("R8 after 100", g, 1'b0);
        // R8: reset discards partial 010
        step(1'b1, 1'b0, 1'b0, g, e);
        step(1'b0, 1'b1, 1'b0, g, e);
        step(1'b0, 1'b1, 1'b1, g, e);
        step(1'b1, 1'b0, 1'b0, g, e);
        step(1'b0, 1'b1, 1'b0, g, e); check("R8 after 01", g, 1'b0);
        // R5: 0,1,0,0,1 hits on third and fifth bit
        step(1'b1, 1'b0, 1'b0, g, e);
        step(1'b0, 1'b1, 1'b0, g, e);
        step(1'b0, 1'b1, 1'b1, g, e);
        step(1'b0, 1'b1, 1'b0, g, e); check("R5 third", g, 1'b1);
        step(1'b0, 1'b1, 1'b0, g, e); check("R5 fourth", g, 1'b0);
        step(1'b0, 1'b1, 1'b1, g, e); check("R5 fifth", g, 1'b1);

        // R2 R3 R4 R6: random stream against shift-register model
        for (int k = 0; k < 3000; k++) begin
            logic rr;
            logic vv;
            logic bb;
            rr = ($urandom_range(0, 99) == 0);
            vv = ($urandom_range(0, 3) != 0);
            bb = $urandom_range(0, 1);
            step(rr, vv, bb, g, e);
            if (!rr) check("R2/R3/R4/R6 random", g, e);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule